// File: doc/BRIEF.md
# Two-Channel Mapped Interrupt Controller

This block gathers a set of physical interrupt lines and drives two independent active-low request outputs toward a processor: a fast channel, which the processor services ahead of everything else, and a normal channel. The two channels behave in the same way. The only difference between them is which logical interrupts feed each one.

Every logical interrupt has its own configuration word. The word picks the physical line that drives the interrupt. It also sets whether that line is sampled as a level or latched on an edge, whether the line is active high or active low, and whether the interrupt may reach its channel. Edge-latched requests stay pending until software clears them. Software reads the masked and unmasked pending bits of each channel through a small word-addressed register bus. Physical lines are first passed through a two-flop synchronizer.

Top module: `irq_dual_map`

## Requirements
- R1: After reset both request outputs are high, every configuration word reads 0, and the four pending registers read 0 while the physical inputs are low.
- R2: The configuration word of logical interrupt i is at bus address i. Bits [7:0] select the physical input, bit 8 selects edge mode, bit 9 selects active-low, and bit 10 enables the interrupt. Reads return bits [10:0] as written, with zeros above.
- R3: In level mode the raw pending bit follows the selected input, inverted when bit 9 is set. A select value at or above the number of physical inputs reads as a constant low line.
- R4: In edge mode a rising edge (falling edge when bit 9 is set) of the selected input sets the raw pending bit. The bit stays set after the input returns.
- R5: A write to address 40 clears the edge latch of every logical interrupt whose bit is 1 in the written data. Latches whose bit is 0 are unaffected, and the write has no effect on level-mode interrupts.
- R6: When a selected edge and a clear of the same interrupt take effect in the same cycle, the latch stays set.
- R7: A disabled interrupt still shows in the raw registers. It is absent from the status registers and never drives an output.
- R8: Logical interrupts 0..3 belong to the fast channel and 4..23 to the normal channel. Fast status and raw are read at addresses 32 and 33, with bit i being logical i. Normal status and raw are read at 34 and 35, with bit j being logical 4+j. `fastReqN` and `normReqN` are low while their channel's status is nonzero.
- R9: A level change driven on a physical input just after a clock edge reaches the request output after the second following edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| physIn | input | 8 | Asynchronous physical interrupt lines |
| busAddr | input | 6 | Register word address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| fastReqN | output | 1 | Fast channel request, active low |
| normReqN | output | 1 | Normal channel request, active low |

## Verification
The two functions that can fall in the same cycle are the setting of an edge latch by a freshly synchronized edge and a software clear aimed at that same latch. The bench counts the synchronizer and edge-detector registers and then places the clear write exactly on the clock edge where the latch sets. It judges the result by reading the raw register and the normal request output afterwards, both of which must still show the request. A following clear with no coincident edge must then remove it, which shows that the clear path itself works.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADDR_FAST_STAT = 6'd32;
  localparam logic [ADDR_W-1:0] ADDR_FAST_RAW  = 6'd33;
  localparam logic [ADDR_W-1:0] ADDR_NORM_STAT = 6'd34;
  localparam logic [ADDR_W-1:0] ADDR_NORM_RAW  = 6'd35;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR     = 6'd40;

  // Configuration word, MSB first: enable, activeLow, edgeMode, sel
  typedef struct packed {
    logic       enable;
    logic       activeLow;
    logic       edgeMode;
    logic [7:0] sel;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic              clrWr;
    logic [DATA_W-1:0] clrMask;
  } strobe_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NUM_FAST = 4,
  parameter int NUM_NORM = 20,
  localparam int NUM_LOG = NUM_FAST + NUM_NORM
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] fastStat,
  input  logic [DATA_W-1:0] fastRaw,
  input  logic [DATA_W-1:0] normStat,
  input  logic [DATA_W-1:0] normRaw,
  output cfg_t              cfgVec [NUM_LOG],
  output strobe_t           stb,
  output logic [DATA_W-1:0] busRdData
);
  cfg_t cfgQ [NUM_LOG];

  for (genvar i = 0; i < NUM_LOG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgQ[i] <= '0;
      else if (busWrEn && busAddr == ADDR_W'(i))
        cfgQ[i] <= cfg_t'(busWrData[CFG_W-1:0]);
    end
    assign cfgVec[i] = cfgQ[i];
  end

  always_comb begin
    stb.clrWr   = busWrEn && (busAddr == ADDR_CLEAR);
    stb.clrMask = busWrData;
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_LOG; i++)
      if (busAddr == ADDR_W'(i)) busRdData = DATA_W'(cfgQ[i]);
    case (busAddr)
      ADDR_FAST_STAT: busRdData = fastStat;
      ADDR_FAST_RAW:  busRdData = fastRaw;
      ADDR_NORM_STAT: busRdData = normStat;
      ADDR_NORM_RAW:  busRdData = normRaw;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_core.sv
module irq_core
  import irq_pkg::*;
#(
  parameter int NUM_PHYS = 8,
  parameter int NUM_FAST = 4,
  parameter int NUM_NORM = 20,
  localparam int NUM_LOG = NUM_FAST + NUM_NORM,
  localparam int SEL_W = (NUM_PHYS > 1) ? $clog2(NUM_PHYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PHYS-1:0] physIn,
  input  cfg_t                cfgVec [NUM_LOG],
  input  strobe_t             stb,
  output logic [NUM_LOG-1:0]  rawVec,
  output logic [NUM_LOG-1:0]  enVec,
  output logic [NUM_LOG-1:0]  edgeVec,
  output logic [DATA_W-1:0]   fastStat,
  output logic [DATA_W-1:0]   fastRaw,
  output logic [DATA_W-1:0]   normStat,
  output logic [DATA_W-1:0]   normRaw,
  output logic                fastReqN,
  output logic                normReqN
);
  logic [NUM_PHYS-1:0] syncA, syncB;
  logic [NUM_LOG-1:0]  statVec;
  logic                unusedClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= physIn;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < NUM_LOG; i++) begin : g_log
    logic curSel, prevSel, hit, latchQ;
    logic [SEL_W-1:0] idx;

    assign idx    = cfgVec[i].sel[SEL_W-1:0];
    assign curSel = (int'(cfgVec[i].sel) < NUM_PHYS) && syncB[idx];
    assign hit    = cfgVec[i].activeLow ? (prevSel & ~curSel) : (curSel & ~prevSel);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevSel <= 1'b0;
        latchQ  <= 1'b0;
      end else begin
        prevSel <= curSel;
        if (!cfgVec[i].edgeMode) latchQ <= 1'b0;
        else if (hit) latchQ <= 1'b1;
        else if (stb.clrWr && stb.clrMask[i]) latchQ <= 1'b0;
      end
    end

    assign rawVec[i]  = cfgVec[i].edgeMode ? latchQ : (curSel ^ cfgVec[i].activeLow);
    assign enVec[i]   = cfgVec[i].enable;
    assign edgeVec[i] = cfgVec[i].edgeMode;
  end

  assign statVec   = rawVec & enVec;
  assign fastRaw   = DATA_W'(rawVec[NUM_FAST-1:0]);
  assign fastStat  = DATA_W'(statVec[NUM_FAST-1:0]);
  assign normRaw   = DATA_W'(rawVec[NUM_LOG-1:NUM_FAST]);
  assign normStat  = DATA_W'(statVec[NUM_LOG-1:NUM_FAST]);
  assign fastReqN  = ~|statVec[NUM_FAST-1:0];
  assign normReqN  = ~|statVec[NUM_LOG-1:NUM_FAST];
  assign unusedClr = ^stb.clrMask[DATA_W-1:NUM_LOG];
endmodule

// File: rtl/irq_dual_map.sv
module irq_dual_map
  import irq_pkg::*;
#(
  parameter int NUM_PHYS = 8,
  parameter int NUM_FAST = 4,
  parameter int NUM_NORM = 20,
  localparam int NUM_LOG = NUM_FAST + NUM_NORM
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PHYS-1:0] physIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  output logic                fastReqN,
  output logic                normReqN
);
  cfg_t              cfgVec [NUM_LOG];
  strobe_t           stb;
  logic [NUM_LOG-1:0] rawVec, enVec, edgeVec;
  logic [DATA_W-1:0] fastStat, fastRaw, normStat, normRaw;

  irq_regs #(.NUM_FAST(NUM_FAST), .NUM_NORM(NUM_NORM)) uRegs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .fastStat(fastStat), .fastRaw(fastRaw),
    .normStat(normStat), .normRaw(normRaw), .cfgVec(cfgVec), .stb(stb),
    .busRdData(busRdData)
  );

  irq_core #(.NUM_PHYS(NUM_PHYS), .NUM_FAST(NUM_FAST), .NUM_NORM(NUM_NORM)) uCore (
    .clk(clk), .rstN(rstN), .physIn(physIn), .cfgVec(cfgVec), .stb(stb),
    .rawVec(rawVec), .enVec(enVec), .edgeVec(edgeVec),
    .fastStat(fastStat), .fastRaw(fastRaw), .normStat(normStat), .normRaw(normRaw),
    .fastReqN(fastReqN), .normReqN(normReqN)
  );
endmodule

// File: rtl/irq_dual_map_chk.sv
module irq_dual_map_chk
  import irq_pkg::*;
#(
  parameter int NUM_FAST = 4,
  parameter int NUM_LOG = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [NUM_LOG-1:0] rawVec,
  input logic [NUM_LOG-1:0] enVec,
  input logic [NUM_LOG-1:0] edgeVec,
  input strobe_t            stb,
  input logic               fastReqN,
  input logic               normReqN
);
  AST_FAST_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (|(rawVec[NUM_FAST-1:0] & enVec[NUM_FAST-1:0])) == !fastReqN); // R8

  AST_NORM_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (|(rawVec[NUM_LOG-1:NUM_FAST] & enVec[NUM_LOG-1:NUM_FAST])) == !normReqN); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == '0) |-> (fastReqN && normReqN)); // R7

  AST_CLEAR_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrWr |-> (busWrEn && busAddr == ADDR_CLEAR)); // R5

  for (genvar i = 0; i < NUM_LOG; i++) begin : g_hold
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (edgeVec[i] && rawVec[i] && !(stb.clrWr && stb.clrMask[i]))
        |=> (!edgeVec[i] || rawVec[i])); // R4
  end
endmodule

bind irq_dual_map irq_dual_map_chk #(.NUM_FAST(NUM_FAST), .NUM_LOG(NUM_LOG)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .rawVec(rawVec), .enVec(enVec), .edgeVec(edgeVec), .stb(stb),
  .fastReqN(fastReqN), .normReqN(normReqN)
);

// File: tb/sim_irq_dual_map.sv
`timescale 1ns/1ps
module sim_irq_dual_map;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  physIn = '0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        fastReqN, normReqN;
  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  irq_dual_map u0 (
    .clk(clk), .rstN(rstN), .physIn(physIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .fastReqN(fastReqN), .normReqN(normReqN)
  );

  typedef struct packed {
    logic [4:0] lg;
    logic [7:0] sel;
    logic       edg, inv, en;
    logic [7:0] pre, post;
    logic       expRaw, expFastN, expNormN;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{5'd0,  8'd2, 1'b0, 1'b0, 1'b1, 8'h00, 8'h04, 1'b1, 1'b0, 1'b1},
    '{5'd0,  8'd2, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},
    '{5'd5,  8'd7, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0},
    '{5'd5,  8'd7, 1'b0, 1'b1, 1'b1, 8'h00, 8'h80, 1'b0, 1'b1, 1'b1},
    '{5'd23, 8'd3, 1'b1, 1'b0, 1'b1, 8'h00, 8'h08, 1'b1, 1'b1, 1'b0},
    '{5'd23, 8'd3, 1'b1, 1'b0, 1'b1, 8'h08, 8'h00, 1'b0, 1'b1, 1'b1},
    '{5'd3,  8'd1, 1'b1, 1'b1, 1'b1, 8'h02, 8'h00, 1'b1, 1'b0, 1'b1},
    '{5'd3,  8'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h02, 1'b1, 1'b1, 1'b1},
    '{5'd10, 8'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; physIn = '0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic [31:0] cfgWord(input logic en, input logic inv,
                                          input logic edg, input logic [7:0] sel);
    return {21'b0, en, inv, edg, sel};
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 fastReqN", 32'(fastReqN), 32'd1);
    chk("R1 normReqN", 32'(normReqN), 32'd1);
    busRead(6'd7, rd);  chk("R1 cfg7", rd, 0);
    busRead(6'd32, rd); chk("R1 fast stat", rd, 0);
    busRead(6'd33, rd); chk("R1 fast raw", rd, 0);
    busRead(6'd34, rd); chk("R1 norm stat", rd, 0);
    busRead(6'd35, rd); chk("R1 norm raw", rd, 0);

    // R2 readback
    @(negedge clk);
    busWrite(6'd7, 32'h0000_05A3);
    busRead(6'd7, rd); chk("R2 cfg readback", rd, 32'h5A3);
    @(negedge clk);
    busWrite(6'd7, 32'hFFFF_FFFF);
    busRead(6'd7, rd); chk("R2 cfg upper bits zero", rd, 32'h7FF);

    // Vector walk: R3 R4 R7 R8
    foreach (VEC[v]) begin
      logic [5:0] rawA, statA;
      int bitPos;
      doReset();
      physIn = VEC[v].pre;
      busWrite(6'(VEC[v].lg), cfgWord(VEC[v].en, VEC[v].inv, VEC[v].edg, VEC[v].sel));
      waitCyc(4);
      busWrite(6'd40, 32'hFFFF_FFFF);
      physIn = VEC[v].post;
      waitCyc(5);
      rawA   = (VEC[v].lg < 4) ? 6'd33 : 6'd35;
      statA  = (VEC[v].lg < 4) ? 6'd32 : 6'd34;
      bitPos = (VEC[v].lg < 4) ? int'(VEC[v].lg) : int'(VEC[v].lg) - 4;
      busRead(rawA, rd);
      chk($sformatf("R3 R4 R8 vec%0d raw", v), 32'(rd[bitPos]), 32'(VEC[v].expRaw));
      busRead(statA, rd);
      chk($sformatf("R7 R8 vec%0d stat", v), 32'(rd[bitPos]), 32'(VEC[v].expRaw & VEC[v].en));
      chk($sformatf("R8 vec%0d fastReqN", v), 32'(fastReqN), 32'(VEC[v].expFastN));
      chk($sformatf("R8 vec%0d normReqN", v), 32'(normReqN), 32'(VEC[v].expNormN));
    end

    // R9 synchronizer latency
    doReset();
    busWrite(6'd1, cfgWord(1'b1, 1'b0, 1'b0, 8'd4));
    waitCyc(3);
    physIn[4] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 not after one edge", 32'(fastReqN), 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R9 after two edges", 32'(fastReqN), 32'd0);

    // R4 hold after a one-cycle pulse, then R5 clears
    doReset();
    busWrite(6'd23, cfgWord(1'b1, 1'b0, 1'b1, 8'd3));
    waitCyc(3);
    physIn[3] = 1'b1;
    @(negedge clk);
    physIn[3] = 1'b0;
    waitCyc(6);
    chk("R4 pulse held normReqN", 32'(normReqN), 32'd0);
    busRead(6'd35, rd); chk("R4 pulse held raw", 32'(rd[19]), 32'd1);
    @(negedge clk);
    busWrite(6'd40, 32'h0040_0000);
    chk("R5 other bit no clear", 32'(normReqN), 32'd0);
    busWrite(6'd40, 32'h0080_0000);
    chk("R5 clear normReqN", 32'(normReqN), 32'd1);
    busRead(6'd35, rd); chk("R5 clear raw", 32'(rd[19]), 32'd0);

    // R5 clear ignored in level mode
    doReset();
    busWrite(6'd2, cfgWord(1'b1, 1'b0, 1'b0, 8'd5));
    physIn[5] = 1'b1;
    waitCyc(4);
    busWrite(6'd40, 32'h0000_0004);
    waitCyc(1);
    chk("R5 level ignores clear", 32'(fastReqN), 32'd0);

    // R6 set and clear in the same cycle
    doReset();
    busWrite(6'd23, cfgWord(1'b1, 1'b0, 1'b1, 8'd3));
    waitCyc(3);
    physIn[3] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    busAddr = 6'd40; busWrData = 32'h0080_0000; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
    busRead(6'd35, rd); chk("R6 set wins raw", 32'(rd[19]), 32'd1);
    chk("R6 set wins normReqN", 32'(normReqN), 32'd0);
    waitCyc(3);
    chk("R6 still held", 32'(normReqN), 32'd0);
    @(negedge clk);
    busWrite(6'd40, 32'h0080_0000);
    chk("R6 later clear works", 32'(normReqN), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule